// File: doc/BRIEF.md
# SD Card Initialisation Sequencer

This block walks an SD card from power-up to the transfer state on the controller side. It does not drive the card lines itself. It hands one command at a time to a command-issue engine, as an index, an argument and a set of flags. It then reads back the engine's completion, status and response. From those responses it decides the next step. Along the way it keeps the operating-conditions word, the identification word, the card's relative address and the card-specific data word.

It sets the card clock divider in two stages. The identification setting applies from the start, and an operating setting is chosen once the card-specific data is known. Timed pauses and timeouts are measured by counting a free-running millisecond tick.

When the sequence ends, the block raises either a done flag or a fail flag. A failure comes with a negative error code unique to the failing step. The high-capacity and version-2 flags are exported for the transfer logic. Optionally, version-2 cards are switched to high-speed timing before the card-specific data is read.

Top module: `sd_init_seq`

## Requirements
- R1: After reset the sequencer is idle: `cmd_req`, `init_done` and `init_fail` are low and `clk_sel` is 0 (clock off). The `clk_sel` encoding is 0 off, 1 identification, 2 divide-by-2, 3 divide-by-4. A `start` pulse while idle, done or failed selects the identification clock and issues command 0 with no response.
- R2: After command 0 completes successfully, at least `PAUSE_MS` ticks of `ms_tick` pass before the next command is requested. A failure on command 0 ends with error code -1 (0xFF).
- R3: Command 8 is issued with argument 0x1AA and a short response. `ver2` is set only when the command succeeds and response bits 11:0 equal 0x1AA. A failed command 8 is not an error: the sequence continues as for a version-1 card.
- R4: Command 41 is issued with the app-prefix, no-CRC and response flags. Its argument is 0x00FF8000, with bit 30 also set when `ver2` is 1. It is repeated until response bit 31 is 1. That response is stored in `ocr`, and its bit 30 drives `high_cap`.
- R5: If a command-41 response arrives not ready once `ACMD_TO_MS` ticks have passed since the loop began, the sequence fails with -2 (0xFE).
- R6: Command 2 (long response) stores `cid`; a failure gives -3 (0xFD). Command 3 (short response) stores response bits 31:16 in `rca`; a failure gives -4 (0xFC).
- R7: With `HS_SWITCH` set and `ver2` = 1, a switch sequence follows command 3, with these error codes:
  - Command 7 with argument {rca,16'h0} selects the card (-5).
  - Command 13 with the same argument polls until response bits 12:9 equal 4. A failure, or polling longer than `TRAN_TO_MS` ticks, gives -6.
  - Command 6 is sent with argument 0x80FFFFF1 and no response (-7).
  - At least `HS_WAIT_MS` ticks pass.
  - Command 7 with argument 0 and no response deselects the card (-8).

  Version-1 cards skip this sequence.
- R8: Command 9 (long response, argument {rca,16'h0}) stores `csd`; a failure gives -9 (0xF7). On success `clk_sel` becomes 2 when csd bits 103:96 equal 0x5A, else 3.
- R9: A final command 7 with argument {rca,16'h0} and a short response raises `init_done` with `err_code` 0. A failure gives -10 (0xF6).
- R10: The `cmd_flags` bits are: bit 0 response expected, bit 1 long response, bit 2 prefix with the app command, bit 3 ignore response CRC.
- R11: Once raised, `cmd_req` with its index, argument and flags stays stable until `cmd_done`. A new command may be requested in the cycle after `cmd_done`.
- R12: A restart clears `ver2`, `high_cap` and `err_code`, so results never carry over from a previous card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence when idle, done or failed |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cmd_req | output | 1 | Command request to the issue engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_flags | output | 4 | {nocrc, app, long, resp} |
| cmd_done | input | 1 | One-cycle completion pulse from the engine |
| cmd_ok | input | 1 | Command completed without error |
| cmd_resp | input | 128 | Response; short responses in bits 31:0 |
| clk_sel | output | 2 | Card clock divider selection |
| init_done | output | 1 | Card reached transfer state |
| init_fail | output | 1 | Sequence aborted |
| err_code | output | 8 | Two's-complement step error code, 0 on success |
| ocr | output | 32 | Stored operating-conditions word |
| cid | output | 128 | Stored identification word |
| rca | output | 16 | Stored relative card address |
| csd | output | 128 | Stored card-specific data |
| high_cap | output | 1 | High-capacity card |
| ver2 | output | 1 | Version-2 card |

## Verification
The bench runs through card profiles, each chosen to tell one decision apart from the others:
- a correct echo, a missing echo, and an echo whose upper bits are wrong but whose low 12 bits still give a mismatch (separates the version test from a simple response-present test);
- different counts of busy command-41 replies (shows the loop repeats rather than proceeding on the first reply);
- different counts of non-transfer status replies;
- both speed bytes in the card-specific data.

Further directed runs make each step fail in turn and starve the two timeouts, checking that every abort point gives its own code and that a following run starts clean.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_GO_IDLE, S_PAUSE, S_IF_COND, S_OP_COND, S_CID, S_RCA,
        S_HS_SEL, S_HS_STAT, S_HS_SW, S_HS_WAIT, S_HS_DESEL, S_CSD,
        S_SELECT, S_DONE, S_FAIL
    } seq_state_e;

    localparam logic [1:0] CLK_OFF   = 2'd0;
    localparam logic [1:0] CLK_IDENT = 2'd1;
    localparam logic [1:0] CLK_DIV2  = 2'd2;
    localparam logic [1:0] CLK_DIV4  = 2'd3;

    localparam int FL_RESP  = 0;
    localparam int FL_LONG  = 1;
    localparam int FL_APP   = 2;
    localparam int FL_NOCRC = 3;

    localparam logic [7:0] E_GO_IDLE = 8'hFF;
    localparam logic [7:0] E_OP_TO   = 8'hFE;
    localparam logic [7:0] E_CID     = 8'hFD;
    localparam logic [7:0] E_RCA     = 8'hFC;
    localparam logic [7:0] E_HS_SEL  = 8'hFB;
    localparam logic [7:0] E_HS_STAT = 8'hFA;
    localparam logic [7:0] E_HS_SW   = 8'hF9;
    localparam logic [7:0] E_HS_DES  = 8'hF8;
    localparam logic [7:0] E_CSD     = 8'hF7;
    localparam logic [7:0] E_SELECT  = 8'hF6;

    typedef struct packed {
        seq_state_e   st;
        logic [31:0]  ocr;
        logic [127:0] cid;
        logic [127:0] csd;
        logic [15:0]  rca;
        logic [1:0]   clk_sel;
        logic         v2;
        logic         hc;
        logic [7:0]   err;
    } seq_regs_t;

endpackage

// File: rtl/sd_ms_timer.sv
module sd_ms_timer #(
    parameter int LIMIT = 5000,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] count
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick && (cnt_q < CW'(LIMIT)))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R5: saturating count never runs past the longest window
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/sd_resp_fields.sv
module sd_resp_fields (
    input  logic [11:0] echo_in,
    input  logic [1:0]  ocr_top,
    input  logic [3:0]  state_in,
    input  logic [15:0] rca_in,
    input  logic [7:0]  speed_in,
    output logic        echo_match,
    output logic        power_up_done,
    output logic        cap_bit,
    output logic        in_tran,
    output logic        fast_card,
    output logic [15:0] rca_field
);
    localparam logic [11:0] ECHO_PAT   = 12'h1AA;
    localparam logic [3:0]  TRAN_STATE = 4'd4;
    localparam logic [7:0]  HS_SPEED   = 8'h5A;

    assign echo_match    = (echo_in == ECHO_PAT);
    assign power_up_done = ocr_top[1];
    assign cap_bit       = ocr_top[0];
    assign in_tran       = (state_in == TRAN_STATE);
    assign fast_card     = (speed_in == HS_SPEED);
    assign rca_field     = rca_in;
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int PAUSE_MS   = 1,
    parameter int ACMD_TO_MS = 1000,
    parameter int HS_WAIT_MS = 100,
    parameter int TRAN_TO_MS = 5000,
    parameter bit HS_SWITCH  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ms_tick,
    output logic         cmd_req,
    output logic [5:0]   cmd_idx,
    output logic [31:0]  cmd_arg,
    output logic [3:0]   cmd_flags,
    input  logic         cmd_done,
    input  logic         cmd_ok,
    input  logic [127:0] cmd_resp,
    output logic [1:0]   clk_sel,
    output logic         init_done,
    output logic         init_fail,
    output logic [7:0]   err_code,
    output logic [31:0]  ocr,
    output logic [127:0] cid,
    output logic [15:0]  rca,
    output logic [127:0] csd,
    output logic         high_cap,
    output logic         ver2
);
    localparam int MAX_A   = (ACMD_TO_MS > TRAN_TO_MS) ? ACMD_TO_MS : TRAN_TO_MS;
    localparam int MAX_B   = (HS_WAIT_MS > PAUSE_MS) ? HS_WAIT_MS : PAUSE_MS;
    localparam int TMR_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW      = $clog2(TMR_MAX + 1);

    localparam logic [31:0] OP_WINDOW = 32'h00FF_8000;
    localparam logic [31:0] HS_ARG    = 32'h80FF_FFF1;

    seq_regs_t q, d;
    logic [TW-1:0] ms_cnt;
    logic echo_match, power_up_done, cap_bit, in_tran, fast_card;
    logic [15:0] rca_field;
    logic [31:0] addr_arg;

    sd_ms_timer #(.LIMIT(TMR_MAX), .CW(TW)) timer_i (
        .clk(clk), .rst_n(rst_n), .clr(d.st != q.st), .tick(ms_tick), .count(ms_cnt)
    );

    sd_resp_fields fields_i (
        .echo_in(cmd_resp[11:0]), .ocr_top(cmd_resp[31:30]), .state_in(cmd_resp[12:9]),
        .rca_in(cmd_resp[31:16]), .speed_in(cmd_resp[103:96]),
        .echo_match(echo_match), .power_up_done(power_up_done), .cap_bit(cap_bit),
        .in_tran(in_tran), .fast_card(fast_card), .rca_field(rca_field)
    );

    assign addr_arg = {q.rca, 16'h0000};

    // command presented for the current state
    always_comb begin
        cmd_req   = 1'b1;
        cmd_idx   = 6'd0;
        cmd_arg   = 32'h0;
        cmd_flags = 4'b0000;
        case (q.st)
            S_GO_IDLE:  ;
            S_IF_COND:  begin cmd_idx = 6'd8;  cmd_arg = 32'h1AA; cmd_flags[FL_RESP] = 1'b1; end
            S_OP_COND:  begin
                cmd_idx = 6'd41;
                cmd_arg = OP_WINDOW | {1'b0, q.v2, 30'h0};
                cmd_flags[FL_RESP]  = 1'b1;
                cmd_flags[FL_APP]   = 1'b1;
                cmd_flags[FL_NOCRC] = 1'b1;
            end
            S_CID:      begin cmd_idx = 6'd2;  cmd_flags[FL_RESP] = 1'b1; cmd_flags[FL_LONG] = 1'b1; end
            S_RCA:      begin cmd_idx = 6'd3;  cmd_flags[FL_RESP] = 1'b1; end
            S_HS_SEL:   begin cmd_idx = 6'd7;  cmd_arg = addr_arg; cmd_flags[FL_RESP] = 1'b1; end
            S_HS_STAT:  begin cmd_idx = 6'd13; cmd_arg = addr_arg; cmd_flags[FL_RESP] = 1'b1; end
            S_HS_SW:    begin cmd_idx = 6'd6;  cmd_arg = HS_ARG; end
            S_HS_DESEL: begin cmd_idx = 6'd7; end
            S_CSD:      begin cmd_idx = 6'd9;  cmd_arg = addr_arg; cmd_flags[FL_RESP] = 1'b1; cmd_flags[FL_LONG] = 1'b1; end
            S_SELECT:   begin cmd_idx = 6'd7;  cmd_arg = addr_arg; cmd_flags[FL_RESP] = 1'b1; end
            default:    cmd_req = 1'b0;
        endcase
    end

    // next-state computation
    always_comb begin
        d = q;
        case (q.st)
            S_IDLE, S_DONE, S_FAIL:
                if (start) begin
                    d.st      = S_GO_IDLE;
                    d.clk_sel = CLK_IDENT;
                    d.v2      = 1'b0;
                    d.hc      = 1'b0;
                    d.err     = 8'h00;
                end
            S_GO_IDLE:
                if (cmd_done) begin
                    if (cmd_ok) d.st = S_PAUSE;
                    else begin d.st = S_FAIL; d.err = E_GO_IDLE; end
                end
            S_PAUSE:
                if (ms_cnt >= TW'(PAUSE_MS)) d.st = S_IF_COND;
            S_IF_COND:
                if (cmd_done) begin
                    d.v2 = cmd_ok && echo_match;
                    d.st = S_OP_COND;
                end
            S_OP_COND:
                if (cmd_done) begin
                    if (cmd_ok && power_up_done) begin
                        d.ocr = cmd_resp[31:0];
                        d.hc  = cap_bit;
                        d.st  = S_CID;
                    end else if (ms_cnt >= TW'(ACMD_TO_MS)) begin
                        d.st = S_FAIL; d.err = E_OP_TO;
                    end
                end
            S_CID:
                if (cmd_done) begin
                    if (cmd_ok) begin d.cid = cmd_resp; d.st = S_RCA; end
                    else begin d.st = S_FAIL; d.err = E_CID; end
                end
            S_RCA:
                if (cmd_done) begin
                    if (cmd_ok) begin
                        d.rca = rca_field;
                        d.st  = (HS_SWITCH && q.v2) ? S_HS_SEL : S_CSD;
                    end else begin d.st = S_FAIL; d.err = E_RCA; end
                end
            S_HS_SEL:
                if (cmd_done) begin
                    if (cmd_ok) d.st = S_HS_STAT;
                    else begin d.st = S_FAIL; d.err = E_HS_SEL; end
                end
            S_HS_STAT:
                if (cmd_done) begin
                    if (cmd_ok && in_tran) d.st = S_HS_SW;
                    else if (!cmd_ok || (ms_cnt >= TW'(TRAN_TO_MS))) begin
                        d.st = S_FAIL; d.err = E_HS_STAT;
                    end
                end
            S_HS_SW:
                if (cmd_done) begin
                    if (cmd_ok) d.st = S_HS_WAIT;
                    else begin d.st = S_FAIL; d.err = E_HS_SW; end
                end
            S_HS_WAIT:
                if (ms_cnt >= TW'(HS_WAIT_MS)) d.st = S_HS_DESEL;
            S_HS_DESEL:
                if (cmd_done) begin
                    if (cmd_ok) d.st = S_CSD;
                    else begin d.st = S_FAIL; d.err = E_HS_DES; end
                end
            S_CSD:
                if (cmd_done) begin
                    if (cmd_ok) begin
                        d.csd     = cmd_resp;
                        d.clk_sel = fast_card ? CLK_DIV2 : CLK_DIV4;
                        d.st      = S_SELECT;
                    end else begin d.st = S_FAIL; d.err = E_CSD; end
                end
            S_SELECT:
                if (cmd_done) begin
                    if (cmd_ok) d.st = S_DONE;
                    else begin d.st = S_FAIL; d.err = E_SELECT; end
                end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, ocr: '0, cid: '0, csd: '0, rca: '0,
                   clk_sel: CLK_OFF, v2: 1'b0, hc: 1'b0, err: 8'h00};
        end else begin
            q <= d;
        end
    end

    assign clk_sel   = q.clk_sel;
    assign init_done = (q.st == S_DONE);
    assign init_fail = (q.st == S_FAIL);
    assign err_code  = q.err;
    assign ocr       = q.ocr;
    assign cid       = q.cid;
    assign rca       = q.rca;
    assign csd       = q.csd;
    assign high_cap  = q.hc;
    assign ver2      = q.v2;

    // R11: a pending request does not change under the engine
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_idx) && $stable(cmd_arg) && $stable(cmd_flags)));

    // R4: operating-condition polling runs on the identification clock
    a_r4_ident_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_idx == 6'd41) |-> (clk_sel == CLK_IDENT));

    // R9: completion only follows an accepted final select
    a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(cmd_done && cmd_ok && cmd_idx == 6'd7 && cmd_flags[FL_RESP]));

    // R8: a finished card runs on an operating divider
    a_r8_op_clock: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (clk_sel == CLK_DIV2 || clk_sel == CLK_DIV4));

    // R2: every abort reports a negative code
    a_r2_fail_negative: assert property (@(posedge clk) disable iff (!rst_n)
        init_fail |-> err_code[7]);
endmodule

// File: tb/sd_init_seq_tb.sv
module sd_init_seq_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ms_tick = 1'b0;
    logic         cmd_req;
    logic [5:0]   cmd_idx;
    logic [31:0]  cmd_arg;
    logic [3:0]   cmd_flags;
    logic         cmd_done = 1'b0;
    logic         cmd_ok = 1'b0;
    logic [127:0] cmd_resp = '0;
    logic [1:0]   clk_sel;
    logic         init_done, init_fail, high_cap, ver2;
    logic [7:0]   err_code;
    logic [31:0]  ocr;
    logic [127:0] cid, csd;
    logic [15:0]  rca;

    always #5 clk = ~clk;

    sd_init_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
        .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_flags(cmd_flags),
        .cmd_done(cmd_done), .cmd_ok(cmd_ok), .cmd_resp(cmd_resp),
        .clk_sel(clk_sel), .init_done(init_done), .init_fail(init_fail), .err_code(err_code),
        .ocr(ocr), .cid(cid), .rca(rca), .csd(csd), .high_cap(high_cap), .ver2(ver2)
    );

    localparam logic [127:0] CID_VAL = 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677;
    localparam logic [15:0]  RCA_VAL = 16'hB368;

    int total = 0;
    int bad = 0;

    // card model knobs
    int k_c8ok, k_busy, k_hc, k_hs, k_twait, k_fail;
    logic [11:0] k_echo;
    int busy_left, twait_left;

    // logs from the engine model
    int n_cmd [64];
    logic [31:0] arg_of [64];
    logic [3:0]  flags_of [64];
    int first_idx, second_idx;
    int n_log, hold_err;
    int tick_cnt = 0;
    int t_done0, t_acc8, t_done6, t_desel;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_card(input int c8ok, input logic [11:0] echo, input int busy,
                            input int hc, input int hs, input int twait, input int fail);
        k_c8ok = c8ok; k_echo = echo; k_busy = busy; k_hc = hc; k_hs = hs;
        k_twait = twait; k_fail = fail;
    endtask

    // millisecond tick: one cycle high in every two
    initial begin
        forever begin
            @(negedge clk);
            ms_tick = ~ms_tick;
            if (ms_tick) tick_cnt++;
        end
    end

    // command-issue engine model
    initial begin
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (rst_n && cmd_req) begin
                automatic logic [5:0]  idx = cmd_idx;
                automatic logic [31:0] arg = cmd_arg;
                automatic logic [3:0]  fl  = cmd_flags;
                n_cmd[idx]++;
                arg_of[idx] = arg;
                flags_of[idx] = fl;
                if (n_log == 0) first_idx = idx;
                if (n_log == 1) second_idx = idx;
                n_log++;
                if (idx == 6'd8) t_acc8 = tick_cnt;
                if (idx == 6'd7 && arg == 32'h0) t_desel = tick_cnt;
                repeat (2) @(negedge clk);
                if (cmd_idx !== idx || cmd_arg !== arg || cmd_flags !== fl) hold_err++;
                cmd_ok = (k_fail != int'(idx));
                cmd_resp = '0;
                case (idx)
                    6'd8: begin cmd_ok = (k_c8ok != 0); cmd_resp[11:0] = k_echo; end
                    6'd41: begin
                        cmd_resp[31:0] = 32'h00FF_8000;
                        if (busy_left > 0) busy_left--;
                        else begin cmd_resp[31] = 1'b1; cmd_resp[30] = (k_hc != 0); end
                    end
                    6'd2: cmd_resp = CID_VAL;
                    6'd3: cmd_resp[31:0] = {RCA_VAL, 16'h0500};
                    6'd13: begin
                        if (twait_left > 0) begin twait_left--; cmd_resp[12:9] = 4'd3; end
                        else cmd_resp[12:9] = 4'd4;
                    end
                    6'd9: cmd_resp = {24'h002600, (k_hs != 0) ? 8'h5A : 8'h32, 96'h5B59_0000_7F80_0A40_4000_0000};
                    default: ;
                endcase
                if (idx == 6'd0) t_done0 = tick_cnt;
                if (idx == 6'd6) t_done6 = tick_cnt;
                cmd_done = 1'b1;
            end
        end
    end

    task automatic run_case();
        for (int i = 0; i < 64; i++) n_cmd[i] = 0;
        n_log = 0; hold_err = 0; first_idx = -1; second_idx = -1;
        busy_left = k_busy; twait_left = k_twait;
        t_done0 = 0; t_acc8 = 0; t_done6 = 0; t_desel = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int n = 0; n < 40000; n++) begin
            if (init_done || init_fail) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    typedef struct packed {
        logic        c8ok;
        logic [11:0] echo;
        logic [7:0]  busy;
        logic        hc;
        logic        hs;
        logic [3:0]  twait;
        logic        xv2;
        logic [1:0]  xclk;
    } vec_t;

    localparam vec_t VEC [6] = '{
        {1'b1, 12'h1AA, 8'd3, 1'b1, 1'b1, 4'd2, 1'b1, 2'd2},
        {1'b0, 12'h1AA, 8'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd3},
        {1'b1, 12'h1AA, 8'd5, 1'b0, 1'b0, 4'd0, 1'b1, 2'd3},
        {1'b1, 12'h2AB, 8'd1, 1'b0, 1'b1, 4'd0, 1'b0, 2'd2},
        {1'b1, 12'h1AA, 8'd0, 1'b1, 1'b0, 4'd5, 1'b1, 2'd3},
        {1'b0, 12'h000, 8'd2, 1'b1, 1'b1, 4'd0, 1'b0, 2'd2}
    };

    initial begin
        set_card(1, 12'h1AA, 0, 0, 0, 0, -1);
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 req after reset", cmd_req, 0);
        chk("R1 clk_sel after reset", clk_sel, 0);
        chk("R1 done after reset", init_done, 0);
        chk("R1 fail after reset", init_fail, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle without start", cmd_req, 0);

        for (int v = 0; v < 6; v++) begin
            automatic vec_t t = VEC[v];
            set_card(int'(t.c8ok), t.echo, int'(t.busy), int'(t.hc), int'(t.hs), int'(t.twait), -1);
            run_case();
            chk("R9 done", init_done, 1);
            chk("R9 err zero", err_code, 0);
            chk("R1 first command is 0", first_idx, 0);
            chk("R10 cmd0 flags", flags_of[0], 4'b0000);
            chk("R3 second command is 8", second_idx, 8);
            chk("R3 cmd8 arg", arg_of[8], 32'h1AA);
            chk("R2 pause ticks", (t_acc8 - t_done0) >= 1, 1);
            chk("R3 R12 ver2", ver2, t.xv2);
            chk("R4 acmd41 arg", arg_of[41], 32'h00FF8000 | (t.xv2 ? 32'h4000_0000 : 32'h0));
            chk("R10 acmd41 flags", flags_of[41], 4'b1101);
            chk("R4 acmd41 repeats", n_cmd[41], int'(t.busy) + 1);
            chk("R4 R12 high_cap", high_cap, t.hc);
            chk("R4 ocr ready", ocr[31], 1);
            chk("R6 cid", cid, CID_VAL);
            chk("R10 cmd2 flags", flags_of[2], 4'b0011);
            chk("R6 rca", rca, RCA_VAL);
            chk("R7 switch count", n_cmd[6], t.xv2 ? 1 : 0);
            if (t.xv2) begin
                chk("R7 switch arg", arg_of[6], 32'h80FFFFF1);
                chk("R7 status polls", n_cmd[13], int'(t.twait) + 1);
                chk("R7 wait ticks", (t_desel - t_done6) >= 100, 1);
                chk("R7 select count", n_cmd[7], 3);
            end else begin
                chk("R7 v1 select count", n_cmd[7], 1);
            end
            chk("R8 clk_sel", clk_sel, t.xclk);
            chk("R8 csd speed", csd[103:96], t.hs ? 8'h5A : 8'h32);
            chk("R9 final select arg", arg_of[7], {RCA_VAL, 16'h0});
            chk("R11 request held", hold_err, 0);
        end

        // directed failures
        set_card(1, 12'h1AA, 0, 0, 0, 0, 0);
        run_case();
        chk("R2 cmd0 failure code", err_code, 8'hFF);
        chk("R2 cmd0 failure flag", init_fail, 1);
        chk("R2 nothing after cmd0", n_log, 1);

        set_card(1, 12'h1AA, 100000, 0, 0, 0, -1);
        run_case();
        chk("R5 timeout code", err_code, 8'hFE);
        chk("R5 polled repeatedly", n_cmd[41] > 10, 1);
        chk("R5 no cid after timeout", n_cmd[2], 0);

        set_card(0, 12'h000, 0, 0, 0, 0, -1);
        run_case();
        chk("R3 missing echo is no error", init_done, 1);
        chk("R12 ver2 cleared", ver2, 0);

        set_card(1, 12'h1AA, 0, 0, 0, 0, 2);
        run_case();
        chk("R6 cmd2 failure code", err_code, 8'hFD);

        set_card(1, 12'h1AA, 0, 0, 0, 0, 3);
        run_case();
        chk("R6 cmd3 failure code", err_code, 8'hFC);

        set_card(1, 12'h1AA, 0, 0, 0, 0, 7);
        run_case();
        chk("R7 select failure code", err_code, 8'hFB);

        set_card(0, 12'h1AA, 0, 0, 0, 0, 7);
        run_case();
        chk("R9 final select failure code", err_code, 8'hF6);

        set_card(1, 12'h1AA, 0, 0, 0, 100000, -1);
        run_case();
        chk("R7 transfer timeout code", err_code, 8'hFA);

        set_card(1, 12'h1AA, 0, 0, 0, 0, 6);
        run_case();
        chk("R7 switch failure code", err_code, 8'hF9);

        set_card(0, 12'h1AA, 0, 0, 0, 0, 9);
        run_case();
        chk("R8 cmd9 failure code", err_code, 8'hF7);
        chk("R8 clock stays ident", clk_sel, 2'd1);

        set_card(1, 12'h1AA, 0, 1, 1, 0, -1);
        run_case();
        chk("R12 restart after failure", init_done, 1);
        chk("R12 err cleared", err_code, 0);

        finish_run();
    end
endmodule